// File: doc/BRIEF.md
# Programmable Event Counter Unit

This unit sits next to a memory controller and counts what the controller does. It has eight counters, each 48 bits wide. Every counter picks one event at run time. The event comes from a bus of single-cycle strobes, and a special code makes a counter count every clock instead. Software can preload any counter, so a counter can be set to overflow after a chosen number of events.

Counting is gated at two levels: a global run bit, and a per-counter enable bit. When a counter wraps from all ones to zero, it latches a status bit. Each status bit can be masked. The single interrupt output is raised while any unmasked status bit is set, and software clears status bits by writing ones.

Software reaches the unit through a simple 32-bit register port. Read data is registered. Because a 48-bit counter is read as two words, reading the low word also captures the high word, so the two halves belong together.

Top module: `evcnt_unit`

## Requirements
- R1: After reset all counters, the run bit, the enable bitmap, the status bits and all event codes are zero, the mask register reads 0xFF (all masked), and irq is low.
- R2: Counter n is mapped as follows. Bits 31:0 sit at byte address 0xE00+8n and bits 47:32 sit at 0xE04+8n, carried in data bits 15:0. A write to either word loads that part of the counter, and the loaded value reads back.
- R3: Bit 0 of the control register at 0xEA0 is the run bit. While it is 0, no counter changes except through a software write.
- R4: Bit n of the enable register at 0xE70 gates counter n. A counter with its bit clear does not advance, even when run is set.
- R5: Bits 7:0 of the event-select register at 0xE74+4n hold counter n's code. Code 0 counts every enabled cycle. A code c from 1 to 143 counts the enabled cycles in which ev_in[c] is high. Codes of 144 and above count nothing.
- R6: A software write to a counter word in the same cycle as an increment wins: the written value is stored and the increment is lost.
- R7: When a counter advances from all ones, it becomes zero and sets status bit n at 0x52C, whatever the mask at 0x528 holds. A mask bit of 1 blocks counter n's interrupt.
- R8: The status register is read-only. Writing 1 to bit n of 0x530 clears status bit n, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the bit set.
- R9: irq is high exactly while some status bit is set whose mask bit is 0.
- R10: Reading a counter's low word stores that counter's bits 47:32 in a snapshot. Any later read of a high word returns that snapshot in bits 15:0.
- R11: reg_rdata takes the read value on the clock edge where reg_rd is high, and holds it otherwise. The version register at 0x710 reads 0x00000002, and addresses that map to nothing read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_in | input | 144 | Single-cycle event strobes, one bit per event code |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench goes after these corner cases:
- **Wrap from a preloaded near-full value.** A design that failed to set status when the wrap happened under a mask would lose the overflow silently. A design that carried into a 49th bit would read back a non-zero counter after the wrap.
- **A counter write that lands on an increment.** If the increment won, the counter would read one higher than expected.
- **Status bits.** A clear register that also accepted zeros would wipe bits that software never acknowledged. A status register that accepted writes would also lose bits.
- **Event codes out of range and disabled counters.** These must stay frozen. A design that indexed past the event bus would count at random.

A behavioural reference model runs alongside every clock and compares irq and read data on every cycle while random traffic runs. This catches split-word reads that mix halves from different moments.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] CNT_BASE  = 12'hE00;
  localparam logic [ADDR_W-1:0] SEL_BASE  = 12'hE74;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 12'hE70;
  localparam logic [ADDR_W-1:0] RUN_ADDR  = 12'hEA0;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 12'h528;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 12'h52C;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 12'h530;
  localparam logic [ADDR_W-1:0] VER_ADDR  = 12'h710;
  localparam logic [DATA_W-1:0] VERSION   = 32'h0000_0002;
endpackage

// File: rtl/evcnt_slot.sv
module evcnt_slot #(
  parameter int CNT_W      = 48,
  parameter int NUM_EVENTS = 144,
  parameter int CODE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [CODE_W-1:0]     code,
  input  logic [NUM_EVENTS-1:0] ev_in,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [31:0]           wdata,
  output logic [CNT_W-1:0]      count,
  output logic                  wrap
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  always_comb begin
    if (code == '0)
      hit = 1'b1;
    else if (int'(code) < NUM_EVENTS)
      hit = ev_in[code];
    else
      hit = 1'b0;
  end

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (wr_lo) begin
      cnt_d[31:0] = wdata;
    end else if (wr_hi) begin
      cnt_d[CNT_W-1:32] = wdata[HI_W-1:0];
    end else if (run && hit) begin
      if (&cnt_q) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3: nothing but a write moves a counter that is not running
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  // R5: an out-of-range code never advances the counter
  assert_bad_code_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(code) >= NUM_EVENTS) && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  // R6: a low-word write is stored even when an increment coincides
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q[31:0] == $past(wdata)));

  // R7: a wrap leaves the counter at zero
  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/evcnt_irq.sv
module evcnt_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] wrap,
  input  logic               clr_we,
  input  logic [NUM_CNT-1:0] clr_bits,
  input  logic [NUM_CNT-1:0] mask,
  output logic [NUM_CNT-1:0] status,
  output logic               irq
);
  logic [NUM_CNT-1:0] stat_q, stat_d, clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_bits : '0;
    stat_d  = (stat_q & ~clr_eff) | wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
  assign irq    = |(stat_q & ~mask);

  // R7: every wrap is recorded, masked or not
  assert_wrap_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((stat_q & $past(wrap)) == $past(wrap)));

  // R8: acknowledged bits are gone when no wrap competes
  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (wrap == '0)) |=> ((stat_q & $past(clr_bits)) == '0));

  // R8: status never sets without a wrap
  assert_no_spurious_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap == '0) |=> ((stat_q & ~$past(stat_q)) == '0));
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT    = 8,
  parameter int CNT_W      = 48,
  parameter int NUM_EVENTS = 144,
  parameter int CODE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_EVENTS-1:0] ev_in,
  output logic                  irq
);
  localparam int HI_W = CNT_W - 32;

  logic                      run_q, run_d;
  logic [NUM_CNT-1:0]        en_q, en_d;
  logic [NUM_CNT-1:0]        mask_q, mask_d;
  logic [NUM_CNT-1:0][CODE_W-1:0] code_q, code_d;
  logic [HI_W-1:0]           snap_q, snap_d;
  logic [DATA_W-1:0]         rdata_q, rdata_d;

  logic [NUM_CNT-1:0]        wr_lo, wr_hi, wrap;
  logic [NUM_CNT-1:0][CNT_W-1:0] count;
  logic [NUM_CNT-1:0]        status;
  logic                      clr_we;

  // write decode per counter
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    assign wr_lo[i] = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + 8*i));
    assign wr_hi[i] = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + 8*i + 4));
  end
  assign clr_we = reg_wr && (reg_addr == CLR_ADDR);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    evcnt_slot #(
      .CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS), .CODE_W(CODE_W)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q && en_q[i]),
      .code  (code_q[i]),
      .ev_in (ev_in),
      .wr_lo (wr_lo[i]),
      .wr_hi (wr_hi[i]),
      .wdata (reg_wdata),
      .count (count[i]),
      .wrap  (wrap[i])
    );
  end

  evcnt_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .clr_we   (clr_we),
    .clr_bits (reg_wdata[NUM_CNT-1:0]),
    .mask     (mask_q),
    .status   (status),
    .irq      (irq)
  );

  // control register next state
  always_comb begin
    run_d  = run_q;
    en_d   = en_q;
    mask_d = mask_q;
    code_d = code_q;
    if (reg_wr) begin
      if (reg_addr == RUN_ADDR)  run_d  = reg_wdata[0];
      if (reg_addr == EN_ADDR)   en_d   = reg_wdata[NUM_CNT-1:0];
      if (reg_addr == MASK_ADDR) mask_d = reg_wdata[NUM_CNT-1:0];
      for (int i = 0; i < NUM_CNT; i++) begin
        if (reg_addr == ADDR_W'(SEL_BASE + 4*i)) code_d[i] = reg_wdata[CODE_W-1:0];
      end
    end
  end

  // read path next state
  always_comb begin
    rdata_d = rdata_q;
    snap_d  = snap_q;
    if (reg_rd) begin
      rdata_d = '0;
      if (reg_addr == RUN_ADDR)  rdata_d = DATA_W'(run_q);
      if (reg_addr == EN_ADDR)   rdata_d = DATA_W'(en_q);
      if (reg_addr == MASK_ADDR) rdata_d = DATA_W'(mask_q);
      if (reg_addr == STAT_ADDR) rdata_d = DATA_W'(status);
      if (reg_addr == VER_ADDR)  rdata_d = VERSION;
      for (int i = 0; i < NUM_CNT; i++) begin
        if (reg_addr == ADDR_W'(SEL_BASE + 4*i)) rdata_d = DATA_W'(code_q[i]);
        if (reg_addr == ADDR_W'(CNT_BASE + 8*i)) begin
          rdata_d = count[i][31:0];
          snap_d  = count[i][CNT_W-1:32];
        end
        if (reg_addr == ADDR_W'(CNT_BASE + 8*i + 4)) rdata_d = DATA_W'(snap_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      en_q    <= '0;
      mask_q  <= '1;
      code_q  <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      en_q    <= en_d;
      mask_q  <= mask_d;
      code_q  <= code_d;
      snap_q  <= snap_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  // R11: read data only moves on a read
  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R10: the snapshot only moves on a read
  assert_snap_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(snap_q));

  // R9: with every source masked the interrupt stays low
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);
endmodule

// File: tb/evcnt_unit_test.sv
`timescale 1ns/1ps
module evcnt_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr, reg_rd;
  logic [11:0]  reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [143:0] ev_in;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  evcnt_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_in(ev_in), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [47:0] m_cnt [8];
  logic [7:0]  m_code [8];
  logic        m_run;
  logic [7:0]  m_en, m_mask, m_stat;
  logic [15:0] m_snap;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] v = 32'h0;
    if (a == 12'hEA0) v = {31'h0, m_run};
    if (a == 12'hE70) v = {24'h0, m_en};
    if (a == 12'h528) v = {24'h0, m_mask};
    if (a == 12'h52C) v = {24'h0, m_stat};
    if (a == 12'h710) v = 32'h2;
    for (int i = 0; i < 8; i++) begin
      if (a == 12'(12'hE74 + 4*i)) v = {24'h0, m_code[i]};
      if (a == 12'(12'hE00 + 8*i)) v = m_cnt[i][31:0];
      if (a == 12'(12'hE04 + 8*i)) v = {16'h0, m_snap};
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_cnt[i] = '0; m_code[i] = '0; end
      m_run = 0; m_en = 0; m_mask = 8'hFF; m_stat = 0; m_snap = 0; m_rdata = 0;
    end else begin
      logic [7:0] wraps;
      logic [15:0] snap_new;
      wraps = 0;
      snap_new = m_snap;
      if (reg_rd) begin
        m_rdata = m_read(reg_addr);
        for (int i = 0; i < 8; i++)
          if (reg_addr == 12'(12'hE00 + 8*i)) snap_new = m_cnt[i][47:32];
      end
      m_snap = snap_new;
      for (int i = 0; i < 8; i++) begin
        bit h;
        if (m_code[i] == 0) h = 1;
        else if (m_code[i] < 144) h = ev_in[m_code[i]];
        else h = 0;
        if (reg_wr && reg_addr == 12'(12'hE00 + 8*i))
          m_cnt[i][31:0] = reg_wdata;
        else if (reg_wr && reg_addr == 12'(12'hE04 + 8*i))
          m_cnt[i][47:32] = reg_wdata[15:0];
        else if (m_run && m_en[i] && h) begin
          if (m_cnt[i] == 48'hFFFF_FFFF_FFFF) begin m_cnt[i] = 0; wraps[i] = 1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (reg_wr && reg_addr == 12'h530) m_stat = m_stat & ~reg_wdata[7:0];
      m_stat = m_stat | wraps;
      if (reg_wr) begin
        if (reg_addr == 12'hEA0) m_run  = reg_wdata[0];
        if (reg_addr == 12'hE70) m_en   = reg_wdata[7:0];
        if (reg_addr == 12'h528) m_mask = reg_wdata[7:0];
        for (int i = 0; i < 8; i++)
          if (reg_addr == 12'(12'hE74 + 4*i)) m_code[i] = reg_wdata[7:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R9 interrupt, R11 read data)
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R9 irq vs model", {63'h0, irq}, {63'h0, |(m_stat & ~m_mask)});
      chk("R11 rdata vs model", {32'h0, reg_rdata}, {32'h0, m_rdata});
    end
  end

  // tasks are entered at a falling edge and return at the next one
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] pick_addr();
    int k = int'($urandom % 10);
    int i = int'($urandom % 8);
    case (k)
      0, 1: return 12'(12'hE00 + 8*i);
      2:    return 12'(12'hE04 + 8*i);
      3:    return 12'(12'hE74 + 4*i);
      4:    return 12'hE70;
      5:    return 12'hEA0;
      6:    return 12'h528;
      7:    return 12'h530;
      8:    return 12'h52C;
      default: return (($urandom % 2) == 0) ? 12'h710 : 12'h044;
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; ev_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;

    // R1 reset state, R11 version and unmapped
    chk("R1 irq after reset", {63'h0, irq}, 64'h0);
    rd(12'h52C, v); chk("R1 status reset", v, 32'h0);
    rd(12'h528, v); chk("R1 mask reset", v, 32'hFF);
    rd(12'hEA0, v); chk("R1 run reset", v, 32'h0);
    rd(12'hE00, v); chk("R1 counter0 reset", v, 32'h0);
    rd(12'h710, v); chk("R11 version", v, 32'h2);
    rd(12'h044, v); chk("R11 unmapped reads zero", v, 32'h0);

    // R2 / R10 preload and split read
    wr(12'hE08, 32'hFFFF_FFFE);
    wr(12'hE0C, 32'h0000_FFFF);
    rd(12'hE08, v); chk("R2 low word preload", v, 32'hFFFF_FFFE);
    rd(12'hE0C, v); chk("R10 high word snapshot", v, 32'h0000_FFFF);

    // R7 wrap under mask, R9 unmask, R8 clear rules
    wr(12'hE70, 32'h02);
    wr(12'hEA0, 32'h1);
    idle(1);
    wr(12'hEA0, 32'h0);
    rd(12'hE08, v); chk("R7 counter wraps to zero", v, 32'h0);
    rd(12'h52C, v); chk("R7 status set while masked", v, 32'h02);
    chk("R7 masked wrap keeps irq low", {63'h0, irq}, 64'h0);
    wr(12'h528, 32'hFD);
    chk("R9 unmasked status raises irq", {63'h0, irq}, 64'h1);
    wr(12'h530, 32'h0);
    wr(12'h52C, 32'h0);
    rd(12'h52C, v); chk("R8 zero clear and status write ignored", v, 32'h02);
    wr(12'h530, 32'h02);
    chk("R8 w1c drops irq", {63'h0, irq}, 64'h0);
    rd(12'h52C, v); chk("R8 status cleared", v, 32'h0);

    // R5 event selection
    wr(12'hE80, 32'h83);
    wr(12'hE84, 32'h95);
    wr(12'hE88, 32'h84);
    wr(12'hE70, 32'h38);
    wr(12'hEA0, 32'h1);
    ev_in = '1; ev_in[8'h84] = 1'b0;
    idle(3);
    ev_in = '0;
    wr(12'hEA0, 32'h0);
    rd(12'hE18, v); chk("R5 code 0x83 counts strobes", v, 32'd3);
    rd(12'hE20, v); chk("R5 out-of-range code frozen", v, 32'd0);
    rd(12'hE28, v); chk("R5 quiet strobe not counted", v, 32'd0);
    rd(12'hE30, v); chk("R4 disabled counter frozen", v, 32'd0);

    // R3 run clear freezes everything
    ev_in = '1;
    idle(5);
    ev_in = '0;
    rd(12'hE18, v); chk("R3 stopped counter frozen", v, 32'd3);

    // R6 write beats increment
    wr(12'hE70, 32'h04);
    wr(12'hEA0, 32'h1);
    idle(2);
    wr(12'hE10, 32'h100);
    wr(12'hEA0, 32'h0);
    rd(12'hE10, v); chk("R6 write wins over increment", v, 32'h101);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      for (int w = 0; w < 5; w++) ev_in[w*32 +: 16] = 16'($urandom);
      for (int w = 0; w < 4; w++) ev_in[w*32+16 +: 16] = 16'($urandom);
      case ($urandom % 6)
        0, 1: begin
          logic [11:0] a = pick_addr();
          logic [31:0] d = $urandom;
          if (a[2] && a >= 12'hE00 && a < 12'hE40) d = (($urandom % 2) == 0) ? 32'hFFFF : d;
          if (a >= 12'hE00 && a < 12'hE40 && !a[2] && ($urandom % 2) == 0) d = 32'hFFFF_FFF0;
          if (a >= 12'hE74 && a < 12'hE94) d = (($urandom % 3) == 0) ? 32'h0 : ($urandom % 160);
          wr(a, d);
        end
        2, 3: rd(pick_addr(), v);
        default: idle(1);
      endcase
    end

    cmp_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule